// File: doc/BRIEF.md
# Streaming 4x4 Residue SATD Lane

This block is one candidate lane of a sub-pixel motion search datapath. Every cycle it may accept one row of a 4x4 block: four pixels of the current picture and the four predicted pixels at the same positions. It subtracts prediction from current, runs a 4-point Hadamard butterfly across the row and pushes the row result into a 4x4 register array. Once a whole block sits in the array, its columns are shifted out one per cycle into a second butterfly. The magnitudes of the resulting sixteen coefficients are added, and the sum of absolute transformed differences comes out with a one-cycle valid pulse.

The register array reverses its shift axis after every group of four shifts. While one block's columns leave along one axis, the next block's rows enter along the other, so blocks sent back to back stream through with no idle cycle between them. Rows of a block are sent in four consecutive cycles. Blocks either follow one another directly or are separated by at least four idle cycles. Any cost accumulation over larger partitions happens outside this lane.

Top module: `hadamard_satd_lane`

## Requirements
- R1: While `rst` is high on a rising edge, `satd_valid` and `satd` are zero after that edge.
- R2: Each pixel lane i (bits [8i+7:8i] of `cur_row` and `pred_row`, lane 0 in the low bits) forms the signed residue cur minus pred, with range -255 to +255.
- R3: For a block whose rows are four consecutive accepted input rows, `satd` equals the sum of absolute values of the 2-D Hadamard transform of the 4x4 residue block. The 1-D butterfly of (a,b,c,d) gives a+b+c+d, a+b-c-d, a-b-c+d and a-b+c-d, applied to the rows and then to the columns, without scaling.
- R4: `satd_valid` is high for exactly one cycle per block, after the fifth rising edge that follows the edge that accepted the block's fourth row.
- R5: Blocks sent with no gap give one correct result every four cycles, with no stall and no lost block.
- R6: A gap of four or more idle cycles between blocks does not change any result or its timing rule.
- R7: `satd` keeps its value in every cycle in which `satd_valid` is low.
- R8: Full-scale residues (all +255, or a ±255 pattern that matches one basis vector) give the exact result 4080 with no wrap.
- R9: A block whose current and predicted rows are all identical gives `satd` = 0.
- R10: Data on `cur_row` and `pred_row` while `in_valid` is low has no effect on any result and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Row on the data inputs is part of a block |
| cur_row | input | 4*PIX_W | Four current-picture pixels, lane 0 in the low bits |
| pred_row | input | 4*PIX_W | Four predicted pixels, same lane order |
| satd_valid | output | 1 | One-cycle pulse when `satd` holds a new block result |
| satd | output | PIX_W+9 | Sum of absolute Hadamard coefficients of the last block |

## Verification
The critical overlap is the register array taking in the rows of block n+1 in the same cycles in which it releases the columns of block n along the other axis. This is provoked by long runs of back-to-back random blocks. A wrong shift axis, a wrong column order or a missed mode flip then corrupts the following block's value or moves its pulse. Each pulse is judged against a behavioural matrix transform of the stored block, and against the exact edge on which it must appear, so a shifted, missing or extra pulse is caught as well as a wrong sum.

// File: rtl/satd_lane_pkg.sv
`timescale 1ns/1ps
package satd_lane_pkg;
  typedef enum logic {
    SHIFT_RIGHT = 1'b0,
    SHIFT_DOWN  = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/sl_residue.sv
`timescale 1ns/1ps
module sl_residue #(
  parameter int PIX_W = 8
) (
  input  logic        [PIX_W-1:0] cur  [4],
  input  logic        [PIX_W-1:0] pred [4],
  output logic signed [PIX_W:0]   res  [4]
);
  for (genvar i = 0; i < 4; i++) begin : g_sub
    assign res[i] = $signed({1'b0, cur[i]}) - $signed({1'b0, pred[i]});
  end
endmodule

// File: rtl/sl_hadamard4.sv
`timescale 1ns/1ps
module sl_hadamard4 #(
  parameter int IN_W = 9
) (
  input  logic signed [IN_W-1:0] x [4],
  output logic signed [IN_W+1:0] y [4]
);
  localparam int W1 = IN_W + 1;
  localparam int W2 = IN_W + 2;

  logic signed [W1-1:0] s01, d01, s23, d23;

  assign s01 = W1'(x[0]) + W1'(x[1]);
  assign d01 = W1'(x[0]) - W1'(x[1]);
  assign s23 = W1'(x[2]) + W1'(x[3]);
  assign d23 = W1'(x[2]) - W1'(x[3]);

  assign y[0] = W2'(s01) + W2'(s23);
  assign y[1] = W2'(s01) - W2'(s23);
  assign y[2] = W2'(d01) - W2'(d23);
  assign y[3] = W2'(d01) + W2'(d23);
endmodule

// File: rtl/sl_transpose.sv
`timescale 1ns/1ps
module sl_transpose
  import satd_lane_pkg::*;
#(
  parameter int W = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] din  [4],
  output logic signed [W-1:0] dout [4],
  output logic                dout_valid
);
  logic signed [W-1:0] m [4][4];
  logic [1:0]  phase;
  shift_dir_e  dir;
  logic        wrote;
  logic        loaded;
  logic        shift_en;

  assign shift_en   = in_valid | loaded;
  assign dout_valid = loaded;

  // outgoing vector: first entered row is the farthest one along the axis
  always_comb begin
    for (int k = 0; k < 4; k++) begin
      if (dir == SHIFT_RIGHT) dout[k] = m[3-k][3];
      else                    dout[k] = m[3][3-k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      dir    <= SHIFT_RIGHT;
      wrote  <= 1'b0;
      loaded <= 1'b0;
    end else if (shift_en) begin
      phase <= phase + 2'd1;
      if (phase == 2'd0) wrote <= in_valid;
      if (phase == 2'd3) begin
        dir    <= (dir == SHIFT_RIGHT) ? SHIFT_DOWN : SHIFT_RIGHT;
        loaded <= wrote;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) m[r][c] <= '0;
    end else if (shift_en) begin
      if (dir == SHIFT_RIGHT) begin
        for (int r = 0; r < 4; r++) begin
          m[r][0] <= din[r];
          for (int c = 1; c < 4; c++) m[r][c] <= m[r][c-1];
        end
      end else begin
        for (int c = 0; c < 4; c++) begin
          m[0][c] <= din[c];
          for (int r = 1; r < 4; r++) m[r][c] <= m[r-1][c];
        end
      end
    end
  end
endmodule

// File: rtl/sl_accum.sv
`timescale 1ns/1ps
module sl_accum #(
  parameter int IN_W  = 13,
  parameter int OUT_W = 17
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   coef_valid,
  input  logic signed [IN_W-1:0] coef [4],
  output logic [OUT_W-1:0]       satd,
  output logic                   satd_valid
);
  logic [IN_W-1:0]  mag [4];
  logic [OUT_W-1:0] colsum;
  logic [OUT_W-1:0] acc;
  logic [1:0]       cnt;

  for (genvar i = 0; i < 4; i++) begin : g_abs
    assign mag[i] = coef[i][IN_W-1] ? IN_W'(-coef[i]) : IN_W'(coef[i]);
  end

  always_comb begin
    colsum = '0;
    for (int i = 0; i < 4; i++) colsum = colsum + OUT_W'(mag[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      acc        <= '0;
      satd       <= '0;
      satd_valid <= 1'b0;
    end else begin
      satd_valid <= 1'b0;
      if (coef_valid) begin
        cnt <= cnt + 2'd1;
        acc <= (cnt == 2'd0) ? colsum : acc + colsum;
        if (cnt == 2'd3) begin
          satd       <= acc + colsum;
          satd_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hadamard_satd_lane.sv
`timescale 1ns/1ps
module hadamard_satd_lane #(
  parameter  int PIX_W  = 8,
  localparam int SATD_W = PIX_W + 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [4*PIX_W-1:0]   cur_row,
  input  logic [4*PIX_W-1:0]   pred_row,
  output logic                 satd_valid,
  output logic [SATD_W-1:0]    satd
);
  localparam int RES_W = PIX_W + 1;
  localparam int ROW_W = RES_W + 2;
  localparam int COL_W = ROW_W + 2;

  logic        [PIX_W-1:0] cur_px  [4];
  logic        [PIX_W-1:0] pred_px [4];
  logic signed [RES_W-1:0] res     [4];
  logic signed [ROW_W-1:0] row_coef[4];
  logic signed [ROW_W-1:0] col_vec [4];
  logic signed [COL_W-1:0] col_coef[4];
  logic signed [COL_W-1:0] col_q   [4];
  logic                    col_vec_v;
  logic                    col_v;

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign cur_px[i]  = cur_row[i*PIX_W +: PIX_W];
    assign pred_px[i] = pred_row[i*PIX_W +: PIX_W];
  end

  sl_residue #(.PIX_W(PIX_W)) u_res (
    .cur (cur_px),
    .pred(pred_px),
    .res (res)
  );

  sl_hadamard4 #(.IN_W(RES_W)) u_row_h (
    .x(res),
    .y(row_coef)
  );

  sl_transpose #(.W(ROW_W)) u_tp (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .din       (row_coef),
    .dout      (col_vec),
    .dout_valid(col_vec_v)
  );

  sl_hadamard4 #(.IN_W(ROW_W)) u_col_h (
    .x(col_vec),
    .y(col_coef)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_v <= 1'b0;
      for (int i = 0; i < 4; i++) col_q[i] <= '0;
    end else begin
      col_v <= col_vec_v;
      for (int i = 0; i < 4; i++) col_q[i] <= col_coef[i];
    end
  end

  sl_accum #(.IN_W(COL_W), .OUT_W(SATD_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .coef_valid(col_v),
    .coef      (col_q),
    .satd      (satd),
    .satd_valid(satd_valid)
  );
endmodule

// File: rtl/satd_lane_chk.sv
`timescale 1ns/1ps
module satd_lane_chk #(
  parameter int PIX_W  = 8,
  parameter int SATD_W = PIX_W + 9
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [4*PIX_W-1:0] cur_row,
  input logic [4*PIX_W-1:0] pred_row,
  input logic               satd_valid,
  input logic [SATD_W-1:0]  satd
);
  logic [1:0] row_cnt;
  logic       eq_acc;
  logic [5:0] done_sr;
  logic [5:0] eq_sr;
  logic       eq_row, blk_done, blk_eq;

  assign eq_row   = (cur_row == pred_row);
  assign blk_done = in_valid && (row_cnt == 2'd3);
  assign blk_eq   = (row_cnt == 2'd0) ? eq_row : (eq_acc & eq_row);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_cnt <= '0;
      eq_acc  <= 1'b0;
      done_sr <= '0;
      eq_sr   <= '0;
    end else begin
      if (in_valid) begin
        row_cnt <= row_cnt + 2'd1;
        eq_acc  <= blk_eq;
      end
      done_sr <= {done_sr[4:0], blk_done};
      eq_sr   <= {eq_sr[4:0], blk_done & blk_eq};
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!satd_valid && satd == '0)); // R1

  AST_PULSE_TIMING: assert property (@(posedge clk) disable iff (rst)
    satd_valid == done_sr[5]); // R4

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    satd_valid |=> !satd_valid); // R5

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !satd_valid |-> $stable(satd)); // R7

  AST_ZERO_RESIDUE: assert property (@(posedge clk) disable iff (rst)
    (done_sr[5] && eq_sr[5]) |-> (satd == '0)); // R9
endmodule

bind hadamard_satd_lane satd_lane_chk #(.PIX_W(PIX_W), .SATD_W(SATD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .cur_row   (cur_row),
  .pred_row  (pred_row),
  .satd_valid(satd_valid),
  .satd      (satd)
);

// File: tb/test_hadamard_satd_lane.sv
`timescale 1ns/1ps
module test_hadamard_satd_lane;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] cur_row = '0;
  logic [31:0] pred_row = '0;
  logic        satd_valid;
  logic [16:0] satd;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int cur_b [16];
  int pred_b[16];
  int exp_val[256];
  int exp_cyc[256];
  string exp_tag[256];
  int wr = 0;
  int rd = 0;
  int last_satd = 0;
  bit done = 1'b0;

  hadamard_satd_lane #(.PIX_W(8)) i_hadamard_satd_lane (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .cur_row(cur_row), .pred_row(pred_row),
    .satd_valid(satd_valid), .satd(satd)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic fail(input string req, input int act, input int expv);
    errors++;
    $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
  endtask

  function automatic int hs(input int k, input int n);
    case (k)
      0: return 1;
      1: return (n < 2) ? 1 : -1;
      2: return (n == 0 || n == 3) ? 1 : -1;
      default: return (n == 0 || n == 2) ? 1 : -1;
    endcase
  endfunction

  function automatic int ref_satd();
    int d[4][4];
    int t[4][4];
    int s = 0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) d[r][c] = cur_b[r*4+c] - pred_b[r*4+c];
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 4; k++) begin
        t[r][k] = 0;
        for (int c = 0; c < 4; c++) t[r][k] += hs(k, c) * d[r][c];
      end
    for (int k2 = 0; k2 < 4; k2++)
      for (int k = 0; k < 4; k++) begin
        int u = 0;
        for (int r = 0; r < 4; r++) u += hs(k2, r) * t[r][k];
        s += (u < 0) ? -u : u;
      end
    return s;
  endfunction

  // result monitor: pulse position (R4) and value (tag of the block), hold (R7)
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit exp_now;
      exp_now = (rd < wr) && (exp_cyc[rd] == cyc);
      if (satd_valid || exp_now) begin
        checks++;
        if (satd_valid !== exp_now) fail("R4 pulse", int'(satd_valid), int'(exp_now));
        else if (int'(satd) != exp_val[rd]) fail(exp_tag[rd], int'(satd), exp_val[rd]);
        if (exp_now) rd++;
      end else begin
        checks++;
        if (int'(satd) != last_satd) fail("R7 hold", int'(satd), last_satd);
      end
      last_satd = int'(satd);
    end
  end

  always @(posedge clk) begin
    if (cyc == 50000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", rd, wr);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic send_block(input string tag);
    exp_val[wr] = ref_satd();
    exp_tag[wr] = tag;
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      in_valid = 1'b1;
      for (int c = 0; c < 4; c++) begin
        cur_row[c*8 +: 8]  = 8'(cur_b[r*4+c]);
        pred_row[c*8 +: 8] = 8'(pred_b[r*4+c]);
      end
    end
    exp_cyc[wr] = cyc + 1 + 5;
    wr++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      cur_row  = $urandom;
      pred_row = $urandom;
    end
  endtask

  task automatic wait_results();
    idle(4);
    while (rd < wr) idle(1);
    idle(2);
  endtask

  task automatic rand_block();
    for (int i = 0; i < 16; i++) begin
      cur_b[i]  = $urandom_range(0, 255);
      pred_b[i] = $urandom_range(0, 255);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    checks++;
    if (satd_valid !== 1'b0) fail("R1 valid", int'(satd_valid), 0);
    checks++;
    if (satd !== '0) fail("R1 satd", int'(satd), 0);
  endtask

  task automatic t_single();
    rand_block();
    send_block("R2 R3 single block");
    wait_results();
  endtask

  task automatic t_zero();
    for (int i = 0; i < 16; i++) begin
      cur_b[i] = $urandom_range(0, 255);
      pred_b[i] = cur_b[i];
    end
    send_block("R9 identical rows");
    wait_results();
  endtask

  task automatic t_extremes();
    for (int i = 0; i < 16; i++) begin cur_b[i] = 255; pred_b[i] = 0; end
    send_block("R8 flat full scale");
    for (int i = 0; i < 16; i++) begin
      int s = hs(1, i / 4) * hs(2, i % 4);
      cur_b[i]  = (s > 0) ? 255 : 0;
      pred_b[i] = (s > 0) ? 0 : 255;
    end
    send_block("R8 basis full scale");
    wait_results();
    checks++;
    if (exp_val[wr-1] != 4080 || exp_val[wr-2] != 4080)
      fail("R8 model", exp_val[wr-1], 4080);
  endtask

  task automatic t_back_to_back();
    for (int b = 0; b < 10; b++) begin
      rand_block();
      send_block("R5 back to back");
    end
    wait_results();
  endtask

  task automatic t_gaps();
    for (int b = 0; b < 4; b++) begin
      rand_block();
      send_block("R6 R10 block after gap");
      idle(4 + b * 3);
    end
    wait_results();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_zero();
    t_extremes();
    t_back_to_back();
    t_gaps();
    t_single();
    checks++;
    if (rd != wr) fail("R4 pending", rd, wr);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule